// File: doc/BRIEF.md
# Programmable USB Frame Timer

This block produces the periodic start-of-frame tick for a USB host controller. A counter runs on the 12 MHz frame clock, and one frame lasts a fixed base of 11936 clocks plus a 7-bit offset that software sets through a byte-wide timing register. The counter wraps to zero at the end of each frame. On that wrap it raises a one-clock SOF pulse.

Software writes the offset through a simple write strobe and can read it back at any time. A written value waits in a pending copy. The counter takes it over only at the next frame boundary, so a write never shortens or stretches the frame that is running. The block has two resets: an asynchronous active-low global reset and a synchronous host-controller reset. Both return the timing register to its default of 64, which gives 12000 clocks, or 1 ms at 12 MHz. A run-enable input holds the counter idle while it is low.

Top module: `usb_frame_timer`

## Requirements
- R1: The spacing between successive SOF pulses is exactly 11936 + offset clocks, where the offset is bits 6:0 of the timing register. This covers 11936 clocks for offset 0 and 12063 clocks for offset 127.
- R2: `sof` is high for one clock only, and `frame_count` reads 0 in the cycle in which `sof` is high.
- R3: After reset the timing register reads 0x40, and frames are 12000 clocks long.
- R4: A write made during a frame leaves that frame at its old length. The new length applies from the next frame.
- R5: Bit 7 of a write is ignored, and bit 7 always reads 0. A read returns the last value written (the pending copy) in the cycle after the write.
- R6: While `hc_rst` is high, the register returns to 0x40, `frame_count` is 0 and `sof` stays low.
- R7: A low `rst_n` at once forces the register to 0x40, `frame_count` to 0 and `sof` low.
- R8: After `hc_rst` goes low, the first SOF arrives exactly one full frame after the last clock edge at which `hc_rst` was high.
- R9: While `run_en` is low, `frame_count` stays at 0 and no SOF is produced. After `run_en` rises, a fresh frame of the pending length runs, and its SOF comes one full frame after the last clock edge at which `run_en` was low.
- R10: `frame_count` gives the number of clocks elapsed since the last SOF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz frame counter clock |
| rst_n | input | 1 | Global reset, active low, asserted asynchronously |
| hc_rst | input | 1 | Host-controller reset, synchronous, active high |
| run_en | input | 1 | Counting enable; low holds the counter at zero |
| wr_en | input | 1 | Write strobe for the timing register |
| wr_data | input | 8 | Write data; bits 6:0 are the offset, bit 7 is ignored |
| rd_data | output | 8 | Timing register read value; bit 7 is always 0 |
| sof | output | 1 | One-clock start-of-frame pulse |
| frame_count | output | 14 | Current position within the frame |

## Verification
The hardest case to reach is a write that lands in the middle of a frame, because its effect has to show up one frame later and not in the frame where it happened. The stimulus first syncs to a SOF and counts a known number of clocks. It then writes a very different offset and measures the length of two frames in a row: the first must keep the old length and the second must take the new one. Writes in the table-driven part are held back when the counter is near its wrap, so a write never lands on the frame boundary itself.

// File: rtl/uft_pkg.sv
package uft_pkg;
  // Default frame geometry: base count plus programmable offset
  localparam int UFT_BASE_CNT = 11936;
  localparam int UFT_OFS_W    = 7;
  localparam int UFT_REG_W    = 8;
  localparam int UFT_OFS_RST  = 64;
  localparam int UFT_CNT_W    = $clog2(UFT_BASE_CNT + (1 << UFT_OFS_W));

  typedef enum logic [1:0] {
    CNT_IDLE  = 2'd0,  // held at zero (reset or not running)
    CNT_STEP  = 2'd1,  // ordinary increment
    CNT_WRAP  = 2'd2   // last clock of frame, wrap and emit SOF
  } cnt_op_e;
endpackage

// File: rtl/uft_rst_sync.sv
module uft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/uft_timing_reg.sv
module uft_timing_reg #(
  parameter int REG_W   = 8,
  parameter int OFS_W   = 7,
  parameter int OFS_RST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [OFS_W-1:0] pend_ofs,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(OFS_RST);

  logic [OFS_W-1:0] pend_q;
  logic [OFS_W-1:0] pend_d;
  logic             pend_en;
  logic             unused_rsv;

  // Reserved upper bits are dropped on write
  assign unused_rsv = ^wr_data[REG_W-1:OFS_W];

  always_comb begin
    pend_en = hc_rst | wr_en;
    pend_d  = hc_rst ? RST_VAL : wr_data[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= RST_VAL;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_ofs = pend_q;
  assign rd_data  = {{(REG_W-OFS_W){1'b0}}, pend_q};

  p_wr_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hc_rst) |=> (rd_data[OFS_W-1:0] == $past(wr_data[OFS_W-1:0])));
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1] == 1'b0);
  p_hc_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hc_rst |=> (rd_data == REG_W'(OFS_RST)));
endmodule

// File: rtl/uft_frame_counter.sv
module uft_frame_counter
  import uft_pkg::*;
#(
  parameter int BASE_CNT = 11936,
  parameter int OFS_W    = 7,
  parameter int OFS_RST  = 64,
  parameter int CNT_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_rst,
  input  logic             run_en,
  input  logic [OFS_W-1:0] pend_ofs,
  output logic [CNT_W-1:0] count,
  output logic             sof
);
  localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE_CNT - 1);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(OFS_RST);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFS_W-1:0] act_q, act_d;
  logic             sof_q, sof_d;
  logic [CNT_W-1:0] last_val;
  cnt_op_e          op;

  // Final count of the current frame
  assign last_val = BASE_M1 + CNT_W'(act_q);

  always_comb begin
    if (hc_rst || !run_en)      op = CNT_IDLE;
    else if (cnt_q == last_val) op = CNT_WRAP;
    else                        op = CNT_STEP;
  end

  always_comb begin
    cnt_d = '0;
    sof_d = 1'b0;
    act_d = act_q;
    unique case (op)
      CNT_IDLE: act_d = hc_rst ? RST_VAL : pend_ofs;
      CNT_WRAP: begin
        sof_d = 1'b1;
        act_d = pend_ofs;
      end
      default:  cnt_d = cnt_q + CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
      act_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      sof_q <= sof_d;
      act_q <= act_d;
    end
  end

  assign count = cnt_q;
  assign sof   = sof_q;

  p_sof_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (count == '0));
  p_sof_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= last_val);
  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CNT_STEP) |=> $stable(act_q));
  p_hc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hc_rst |=> (count == '0 && !sof));
  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count == '0 && !sof));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int BASE_CNT    = uft_pkg::UFT_BASE_CNT,
  parameter int OFS_W       = uft_pkg::UFT_OFS_W,
  parameter int REG_W       = uft_pkg::UFT_REG_W,
  parameter int OFS_RST     = uft_pkg::UFT_OFS_RST,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(BASE_CNT + (1 << OFS_W))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_rst,
  input  logic             run_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sof,
  output logic [CNT_W-1:0] frame_count
);
  logic             rst_n_s;
  logic [OFS_W-1:0] pend_ofs;

  uft_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  uft_timing_reg #(
    .REG_W(REG_W), .OFS_W(OFS_W), .OFS_RST(OFS_RST)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .hc_rst   (hc_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pend_ofs (pend_ofs),
    .rd_data  (rd_data)
  );

  uft_frame_counter #(
    .BASE_CNT(BASE_CNT), .OFS_W(OFS_W), .OFS_RST(OFS_RST), .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .hc_rst   (hc_rst),
    .run_en   (run_en),
    .pend_ofs (pend_ofs),
    .count    (frame_count),
    .sof      (sof)
  );
endmodule

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n, hc_rst, run_en, wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        sof;
  logic [13:0] frame_count;
  int          n_vec = 0;
  int          n_err = 0;

  localparam int         NV = 3;
  localparam logic [7:0] WR_TAB  [NV] = '{8'h80, 8'h7F, 8'hC0};
  localparam logic [7:0] RD_TAB  [NV] = '{8'h00, 8'h7F, 8'h40};
  localparam int         LEN_TAB [NV] = '{11936, 12063, 12000};

  usb_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .hc_rst(hc_rst), .run_en(run_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sof(sof), .frame_count(frame_count)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  // Counts clocks until sof is seen high; also checks the pulse shape (R2)
  task automatic to_sof(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sof);
    check(frame_count == 0, "R2 count at sof", int'(frame_count), 0);
  endtask

  task automatic write_reg(input logic [7:0] d);
    while (frame_count > 14'd11900) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int n;
    rst_n = 1'b0; hc_rst = 1'b1; run_en = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h40, "R3 R7 reset value", rd_data, 8'h40);
    check(frame_count == 0, "R7 count in reset", int'(frame_count), 0);
    check(sof == 1'b0, "R7 sof in reset", sof, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hc_rst = 1'b0;
    to_sof(n);
    check(n == 12000, "R8 R3 first frame", n, 12000);

    // Table walk: offset programming and spacing (R1, R5)
    for (int i = 0; i < NV; i++) begin
      write_reg(WR_TAB[i]);
      check(rd_data == RD_TAB[i], "R5 readback", rd_data, RD_TAB[i]);
      to_sof(n);
      to_sof(n);
      check(n == LEN_TAB[i], "R1 spacing", n, LEN_TAB[i]);
      @(negedge clk);
      check(sof == 1'b0, "R2 one clock pulse", sof, 0);
    end

    // Mid-frame write (R4, R10)
    to_sof(n);
    repeat (100) @(negedge clk);
    check(frame_count == 100, "R10 count position", int'(frame_count), 100);
    wr_en = 1'b1; wr_data = 8'h05;
    n = 100;
    do begin
      @(negedge clk);
      n++;
      wr_en = 1'b0;
    end while (!sof);
    check(n == 12000, "R4 current frame kept", n, 12000);
    to_sof(n);
    check(n == 11941, "R4 next frame new", n, 11941);

    // Reserved bit ignored (R5)
    write_reg(8'hFF);
    check(rd_data == 8'h7F, "R5 bit7 ignored", rd_data, 8'h7F);

    // Run enable hold and fresh frame (R9)
    run_en = 1'b0;
    repeat (20) @(negedge clk);
    check(frame_count == 0, "R9 count held", int'(frame_count), 0);
    check(sof == 1'b0, "R9 no sof", sof, 0);
    run_en = 1'b1;
    to_sof(n);
    check(n == 12063, "R9 fresh frame", n, 12063);

    // Host-controller reset mid-frame (R6, R8)
    repeat (50) @(negedge clk);
    hc_rst = 1'b1;
    repeat (5) @(negedge clk);
    check(rd_data == 8'h40, "R6 register default", rd_data, 8'h40);
    check(frame_count == 0, "R6 count zero", int'(frame_count), 0);
    check(sof == 1'b0, "R6 no sof", sof, 0);
    hc_rst = 1'b0;
    to_sof(n);
    check(n == 12000, "R8 first after hc reset", n, 12000);

    // Global reset acts at once (R7)
    write_reg(8'h11);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_data == 8'h40, "R7 async default", rd_data, 8'h40);
    check(frame_count == 0, "R7 async count", int'(frame_count), 0);
    check(sof == 1'b0, "R7 async sof", sof, 0);
    report();
  end
endmodule